// File: doc/BRIEF.md
# Multithreaded Fetch-to-Decode Instruction Queue

This block sits between instruction fetch and the decoder of a four-thread core. Each cycle fetch may offer one aligned 32-byte window holding eight 32-bit instructions, tagged with the hardware thread that owns it and a mask that marks which of the eight slots hold useful instructions. The block keeps the marked slots, packs them in address order, attaches to each the address it was fetched from, and appends them to one queue of 16 entries that all threads share.

The decoder side sees up to four lanes per cycle: the oldest queued instructions, each with its thread tag and address. When the decoder signals ready, every valid lane is taken at the clock edge. A per-thread flush removes all queued instructions of the selected threads in one cycle, closes the gaps and leaves the remaining instructions in their original order.

Top module: `fetch_insn_queue`

## Requirements
- R1: While reset is held and right after it, no lane is valid and the window input is ready for any slot mask.
- R2: Slot k of a window is bits [32k+31:32k] of the window data; its stored address is the window address with the low five bits cleared, plus 4k.
- R3: Only slots whose mask bit is 1 are queued, packed in ascending slot order with no gaps.
- R4: A window is taken only if the number of set mask bits is no greater than 16 minus the entries held at the start of the cycle; otherwise ready is low and nothing of the window is stored.
- R5: Lane l shows the l-th oldest entry; valid lanes are contiguous from lane 0 and number the lesser of four and the entries held.
- R6: With decoder ready high, all valid lanes are removed at the clock edge; with it low, the lanes hold their contents.
- R7: Instructions leave in the order they were accepted, across windows and threads.
- R8: Setting bit t of the flush input removes every held entry of thread t at the next edge, keeps the order of the rest and frees their space; a window accepted in the same cycle is kept, and the lanes in that cycle are unaffected.
- R9: The queue holds exactly 16 entries when full.
- R10: A window with an all-zero mask is accepted and changes nothing.
- R11: Entries from different threads share the queue and carry their 2-bit thread tag to the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_valid_i | input | 1 | Fetch window offered |
| win_ready_o | output | 1 | Window can be taken this cycle |
| win_tid_i | input | 2 | Thread owning the window |
| win_addr_i | input | 32 | Window address (low five bits ignored) |
| win_mask_i | input | 8 | Slot k holds a useful instruction |
| win_data_i | input | 256 | Eight instructions, slot 0 in the low bits |
| flush_i | input | 4 | Bit t flushes thread t |
| dec_ready_i | input | 1 | Decoder takes all valid lanes |
| lane_valid_o | output | 4 | Lane holds an instruction |
| lane_insn_o | output | 128 | Lane instructions, lane 0 in the low bits |
| lane_tid_o | output | 8 | Lane thread tags, 2 bits each |
| lane_pc_o | output | 128 | Lane fetch addresses, 32 bits each |

## Verification
The checks on occupancy assume fetch obeys the handshake: a window counts only in a cycle where ready is high, and the occupancy step checks hold only in cycles without a flush or a decoder take. The flush check assumes the decoder does not rely on lanes of a thread flushed one cycle earlier. The stimulus offers windows freely, including ones that are refused, and combines flushes, same-thread windows and decoder stalls, so every cycle stays inside the handshake rules that these checks rely on.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
  localparam int unsigned NUM_THR = 4;
  localparam int unsigned TID_W   = $clog2(NUM_THR);
  typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/fiq_slot_split.sv
module fiq_slot_split
  import fiq_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned SCNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*INSN_W-1:0] win_data_i,
  input  logic [SLOTS-1:0]        win_mask_i,
  input  logic [ADDR_W-1:0]       win_addr_i,
  output logic [INSN_W-1:0]       slot_insn_o [SLOTS],
  output logic [ADDR_W-1:0]       slot_pc_o   [SLOTS],
  output logic [SCNT_W-1:0]       slot_cnt_o
);
  localparam int unsigned INSN_B = INSN_W / 8;
  localparam int unsigned WIN_B  = SLOTS * INSN_B;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(WIN_B - 1);

  logic [ADDR_W-1:0] base_al;
  logic [SCNT_W-1:0] pos [SLOTS];
  logic [SCNT_W-1:0] acc;

  assign base_al = win_addr_i & ~ALIGN_MASK;

  // packed position of each surviving slot
  always_comb begin
    acc = '0;
    for (int k = 0; k < SLOTS; k++) begin
      pos[k] = acc;
      acc    = acc + SCNT_W'(win_mask_i[k]);
    end
    slot_cnt_o = acc;
  end

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      slot_insn_o[j] = '0;
      slot_pc_o[j]   = '0;
      for (int k = 0; k < SLOTS; k++) begin
        if (win_mask_i[k] && pos[k] == SCNT_W'(j)) begin
          slot_insn_o[j] = win_data_i[k*INSN_W +: INSN_W];
          slot_pc_o[j]   = base_al + ADDR_W'(k * INSN_B);
        end
      end
    end
  end
endmodule

// File: rtl/fiq_entry_store.sv
module fiq_entry_store
  import fiq_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1),
  parameter int unsigned SCNT_W = $clog2(SLOTS + 1),
  parameter int unsigned LCNT_W = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] flush_i,
  input  logic [LCNT_W-1:0]  pop_n_i,
  input  logic               push_i,
  input  tid_t               push_tid_i,
  input  logic [SCNT_W-1:0]  push_n_i,
  input  logic [INSN_W-1:0]  push_insn_i [SLOTS],
  input  logic [ADDR_W-1:0]  push_pc_i   [SLOTS],
  output logic [INSN_W-1:0]  q_insn_o    [DEPTH],
  output logic [ADDR_W-1:0]  q_pc_o      [DEPTH],
  output tid_t               q_tid_o     [DEPTH],
  output logic [CNT_W-1:0]   cnt_o
);
  logic [INSN_W-1:0] q_insn [DEPTH];
  logic [ADDR_W-1:0] q_pc   [DEPTH];
  tid_t              q_tid  [DEPTH];
  logic [CNT_W-1:0]  cnt;

  logic [INSN_W-1:0] n_insn [DEPTH];
  logic [ADDR_W-1:0] n_pc   [DEPTH];
  tid_t              n_tid  [DEPTH];
  logic [CNT_W-1:0]  n_cnt;

  logic [DEPTH-1:0]  keep;
  logic [CNT_W-1:0]  pos [DEPTH];
  logic [CNT_W-1:0]  surv;

  // survivors: held, not taken by decoder, not flushed
  always_comb begin
    surv = '0;
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = (i < int'(cnt)) && !(i < int'(pop_n_i)) && !flush_i[q_tid[i]];
      pos[i]  = surv;
      surv    = surv + CNT_W'(keep[i]);
    end
  end

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      n_insn[j] = q_insn[j];
      n_pc[j]   = q_pc[j];
      n_tid[j]  = q_tid[j];
      for (int i = 0; i < DEPTH; i++) begin
        if (keep[i] && pos[i] == CNT_W'(j)) begin
          n_insn[j] = q_insn[i];
          n_pc[j]   = q_pc[i];
          n_tid[j]  = q_tid[i];
        end
      end
      // append after survivors
      for (int k = 0; k < SLOTS; k++) begin
        if (push_i && k < int'(push_n_i) && int'(surv) + k == j) begin
          n_insn[j] = push_insn_i[k];
          n_pc[j]   = push_pc_i[k];
          n_tid[j]  = push_tid_i;
        end
      end
    end
    n_cnt = push_i ? surv + CNT_W'(push_n_i) : surv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_insn[i] <= '0;
        q_pc[i]   <= '0;
        q_tid[i]  <= '0;
      end
    end else begin
      cnt <= n_cnt;
      for (int i = 0; i < DEPTH; i++) begin
        q_insn[i] <= n_insn[i];
        q_pc[i]   <= n_pc[i];
        q_tid[i]  <= n_tid[i];
      end
    end
  end

  assign q_insn_o = q_insn;
  assign q_pc_o   = q_pc;
  assign q_tid_o  = q_tid;
  assign cnt_o    = cnt;
endmodule

// File: rtl/fiq_lane_drive.sv
module fiq_lane_drive
  import fiq_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1),
  parameter int unsigned LCNT_W = $clog2(LANES + 1)
) (
  input  logic [INSN_W-1:0]       head_insn_i [LANES],
  input  logic [ADDR_W-1:0]       head_pc_i   [LANES],
  input  tid_t                    head_tid_i  [LANES],
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    dec_ready_i,
  output logic [LANES-1:0]        lane_valid_o,
  output logic [LANES*INSN_W-1:0] lane_insn_o,
  output logic [LANES*TID_W-1:0]  lane_tid_o,
  output logic [LANES*ADDR_W-1:0] lane_pc_o,
  output logic [LCNT_W-1:0]       pop_n_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_valid_o[l]                 = int'(cnt_i) > l;
    assign lane_insn_o[l*INSN_W +: INSN_W] = head_insn_i[l];
    assign lane_pc_o[l*ADDR_W +: ADDR_W]   = head_pc_i[l];
    assign lane_tid_o[l*TID_W +: TID_W]    = head_tid_i[l];
  end

  always_comb begin
    if (!dec_ready_i)               pop_n_o = '0;
    else if (int'(cnt_i) >= LANES)  pop_n_o = LCNT_W'(LANES);
    else                            pop_n_o = LCNT_W'(cnt_i);
  end
endmodule

// File: rtl/fetch_insn_queue.sv
module fetch_insn_queue
  import fiq_pkg::*;
#(
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_SLOTS = 8,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned LANES     = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          win_valid_i,
  output logic                          win_ready_o,
  input  logic [TID_W-1:0]              win_tid_i,
  input  logic [ADDR_W-1:0]             win_addr_i,
  input  logic [WIN_SLOTS-1:0]          win_mask_i,
  input  logic [WIN_SLOTS*INSN_W-1:0]   win_data_i,
  input  logic [NUM_THR-1:0]            flush_i,
  input  logic                          dec_ready_i,
  output logic [LANES-1:0]              lane_valid_o,
  output logic [LANES*INSN_W-1:0]       lane_insn_o,
  output logic [LANES*TID_W-1:0]        lane_tid_o,
  output logic [LANES*ADDR_W-1:0]       lane_pc_o
);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned SCNT_W = $clog2(WIN_SLOTS + 1);
  localparam int unsigned LCNT_W = $clog2(LANES + 1);

  logic [INSN_W-1:0] slot_insn [WIN_SLOTS];
  logic [ADDR_W-1:0] slot_pc   [WIN_SLOTS];
  logic [SCNT_W-1:0] slot_cnt;

  logic [INSN_W-1:0] q_insn [DEPTH];
  logic [ADDR_W-1:0] q_pc   [DEPTH];
  tid_t              q_tid  [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [LCNT_W-1:0] pop_n;
  logic              push;

  fiq_slot_split #(
    .INSN_W(INSN_W), .ADDR_W(ADDR_W), .SLOTS(WIN_SLOTS), .SCNT_W(SCNT_W)
  ) u_split (
    .win_data_i (win_data_i),
    .win_mask_i (win_mask_i),
    .win_addr_i (win_addr_i),
    .slot_insn_o(slot_insn),
    .slot_pc_o  (slot_pc),
    .slot_cnt_o (slot_cnt)
  );

  // all-or-nothing: space judged on occupancy at start of cycle
  assign win_ready_o = int'(slot_cnt) <= (DEPTH - int'(cnt));
  assign push        = win_valid_i && win_ready_o;

  fiq_entry_store #(
    .INSN_W(INSN_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SLOTS(WIN_SLOTS),
    .LANES(LANES), .CNT_W(CNT_W), .SCNT_W(SCNT_W), .LCNT_W(LCNT_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .pop_n_i    (pop_n),
    .push_i     (push),
    .push_tid_i (win_tid_i),
    .push_n_i   (slot_cnt),
    .push_insn_i(slot_insn),
    .push_pc_i  (slot_pc),
    .q_insn_o   (q_insn),
    .q_pc_o     (q_pc),
    .q_tid_o    (q_tid),
    .cnt_o      (cnt)
  );

  fiq_lane_drive #(
    .INSN_W(INSN_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .LANES(LANES),
    .CNT_W(CNT_W), .LCNT_W(LCNT_W)
  ) u_lanes (
    .head_insn_i (q_insn[0:LANES-1]),
    .head_pc_i   (q_pc[0:LANES-1]),
    .head_tid_i  (q_tid[0:LANES-1]),
    .cnt_i       (cnt),
    .dec_ready_i (dec_ready_i),
    .lane_valid_o(lane_valid_o),
    .lane_insn_o (lane_insn_o),
    .lane_tid_o  (lane_tid_o),
    .lane_pc_o   (lane_pc_o),
    .pop_n_o     (pop_n)
  );
endmodule

// File: rtl/fiq_checker.sv
module fiq_checker
  import fiq_pkg::*;
#(
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned WIN_SLOTS = 8,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned LANES     = 4,
  parameter int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     win_valid_i,
  input logic                     win_ready_i,
  input logic [TID_W-1:0]         win_tid_i,
  input logic [WIN_SLOTS-1:0]     win_mask_i,
  input logic [NUM_THR-1:0]       flush_i,
  input logic                     dec_ready_i,
  input logic [LANES-1:0]         lane_valid_i,
  input logic [INSN_W-1:0]        lane0_insn_i,
  input logic [LANES*TID_W-1:0]   lane_tid_i,
  input logic [CNT_W-1:0]         cnt_i
);
  logic               take;
  logic [NUM_THR-1:0] flush_q;
  logic               flushed_seen;

  assign take = win_valid_i && win_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= '0;
    else         flush_q <= flush_i & ~(take ? (NUM_THR'(1) << win_tid_i) : '0);
  end

  always_comb begin
    flushed_seen = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (lane_valid_i[l] && flush_q[lane_tid_i[l*TID_W +: TID_W]]) flushed_seen = 1'b1;
  end

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_i) <= DEPTH);

  assert_head_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_i[0] == (cnt_i != '0));

  for (genvar l = 1; l < LANES; l++) begin : g_contig
    assert_lanes_contig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_valid_i[l] |-> lane_valid_i[l-1]);
  end

  assert_accept_grow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !dec_ready_i && flush_i == '0)
    |=> int'(cnt_i) == int'($past(cnt_i)) + $past($countones(win_mask_i)));

  assert_refuse_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_i && !win_ready_i && !dec_ready_i && flush_i == '0) |=> $stable(cnt_i));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_valid_i[0] && !dec_ready_i && flush_i == '0 && !take)
    |=> lane_valid_i[0] && $stable(lane0_insn_i));

  assert_drain_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_ready_i && !take && flush_i == '0)
    |=> int'(cnt_i) == int'($past(cnt_i)) - $past($countones(lane_valid_i)));

  assert_flush_gone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flushed_seen);
endmodule

bind fetch_insn_queue fiq_checker #(
  .INSN_W(INSN_W), .WIN_SLOTS(WIN_SLOTS), .DEPTH(DEPTH), .LANES(LANES)
) u_fiq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_valid_i (win_valid_i),
  .win_ready_i (win_ready_o),
  .win_tid_i   (win_tid_i),
  .win_mask_i  (win_mask_i),
  .flush_i     (flush_i),
  .dec_ready_i (dec_ready_i),
  .lane_valid_i(lane_valid_o),
  .lane0_insn_i(lane_insn_o[INSN_W-1:0]),
  .lane_tid_i  (lane_tid_o),
  .cnt_i       (cnt)
);

// File: tb/fetch_insn_queue_test.sv
module fetch_insn_queue_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] insn;
    logic [1:0]  tid;
    logic [31:0] pc;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         win_valid_i = 1'b0;
  logic         win_ready_o;
  logic [1:0]   win_tid_i = '0;
  logic [31:0]  win_addr_i = '0;
  logic [7:0]   win_mask_i = '0;
  logic [255:0] win_data_i = '0;
  logic [3:0]   flush_i = '0;
  logic         dec_ready_i = 1'b0;
  logic [3:0]   lane_valid_o;
  logic [127:0] lane_insn_o;
  logic [7:0]   lane_tid_o;
  logic [127:0] lane_pc_o;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    seq = 0;
  bit    mon_en = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_insn_queue uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .win_valid_i(win_valid_i), .win_ready_o(win_ready_o),
    .win_tid_i(win_tid_i), .win_addr_i(win_addr_i),
    .win_mask_i(win_mask_i), .win_data_i(win_data_i),
    .flush_i(flush_i), .dec_ready_i(dec_ready_i),
    .lane_valid_o(lane_valid_o), .lane_insn_o(lane_insn_o),
    .lane_tid_o(lane_tid_o), .lane_pc_o(lane_pc_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: drives at negedge, checks ready at +1, updates model at +3
  task automatic drive(input bit v, input logic [1:0] tid, input logic [7:0] mask,
                       input logic [31:0] addr, input logic [3:0] fl,
                       input bit dr, input string tag);
    bit   exp_rdy;
    bit   acc;
    exp_t e;
    exp_t keep_q[$];
    @(negedge clk);
    cur_tag     = tag;
    win_valid_i = v;
    win_tid_i   = tid;
    win_mask_i  = mask;
    win_addr_i  = addr;
    flush_i     = fl;
    dec_ready_i = dr;
    for (int k = 0; k < 8; k++)
      win_data_i[k*32 +: 32] = {tid, 14'(seq), 8'hA5, 8'(k)};
    #1;
    exp_rdy = $countones(mask) <= (16 - sb.size());
    chk(win_ready_o == exp_rdy, "R4", "win_ready", 64'(win_ready_o), 64'(exp_rdy));
    acc = v && exp_rdy;
    #2;
    foreach (sb[i]) if (!fl[sb[i].tid]) keep_q.push_back(sb[i]);
    sb = keep_q;
    if (acc)
      for (int k = 0; k < 8; k++)
        if (mask[k]) begin
          e.insn = {tid, 14'(seq), 8'hA5, 8'(k)};
          e.tid  = tid;
          e.pc   = {addr[31:5], 5'b0} + 32'(4 * k);
          sb.push_back(e);
        end
    seq++;
  endtask

  // monitor: compares lanes against the scoreboard head, pops on take
  always begin
    int n;
    @(negedge clk);
    #2;
    if (mon_en) begin
      n = (sb.size() < 4) ? sb.size() : 4;
      for (int l = 0; l < 4; l++) begin
        chk(lane_valid_o[l] == (l < n), "R5", $sformatf("%s lane%0d valid", cur_tag, l),
            64'(lane_valid_o[l]), 64'(l < n));
        if (l < n) begin
          chk(lane_insn_o[l*32 +: 32] == sb[l].insn, "R7",
              $sformatf("%s lane%0d insn", cur_tag, l), 64'(lane_insn_o[l*32 +: 32]), 64'(sb[l].insn));
          chk(lane_pc_o[l*32 +: 32] == sb[l].pc, "R2",
              $sformatf("%s lane%0d pc", cur_tag, l), 64'(lane_pc_o[l*32 +: 32]), 64'(sb[l].pc));
          chk(lane_tid_o[l*2 +: 2] == sb[l].tid, "R11",
              $sformatf("%s lane%0d tid", cur_tag, l), 64'(lane_tid_o[l*2 +: 2]), 64'(sb[l].tid));
        end
      end
      if (dec_ready_i) for (int l = 0; l < n; l++) void'(sb.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    win_mask_i = 8'hFF;
    #3;
    chk(lane_valid_o == 4'b0, "R1", "lanes in reset", 64'(lane_valid_o), 64'h0);
    chk(win_ready_o == 1'b1, "R1", "ready in reset", 64'(win_ready_o), 64'h1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(lane_valid_o == 4'b0, "R1", "lanes after reset", 64'(lane_valid_o), 64'h0);
    chk(win_ready_o == 1'b1, "R1", "ready after reset", 64'(win_ready_o), 64'h1);
    mon_en = 1'b1;

    drive(1, 2'd0, 8'hFF, 32'h0000_1000, 4'h0, 0, "R2");
    drive(1, 2'd1, 8'hF8, 32'h0000_2014, 4'h0, 0, "R3");   // 13 held
    drive(1, 2'd2, 8'h0F, 32'h0000_3000, 4'h0, 0, "R4");   // 4 > 3 free: refused
    drive(1, 2'd2, 8'h07, 32'h0000_3000, 4'h0, 0, "R9");   // fills to 16
    drive(1, 2'd3, 8'h01, 32'h0000_4000, 4'h0, 0, "R9");   // full: refused
    drive(1, 2'd3, 8'h00, 32'h0000_4000, 4'h0, 0, "R10");  // empty mask taken
    drive(1, 2'd3, 8'h01, 32'h0000_4000, 4'h0, 0, "R10");  // still full
    drive(0, 2'd0, 8'h00, 32'h0, 4'h0, 0, "R6");
    drive(0, 2'd0, 8'h00, 32'h0, 4'h0, 0, "R6");
    drive(0, 2'd0, 8'h00, 32'h0, 4'b0010, 0, "R8");        // drop thread 1
    drive(1, 2'd3, 8'h1F, 32'h0000_5000, 4'h0, 0, "R8");   // freed space reused
    repeat (3) drive(0, 2'd0, 8'h00, 32'h0, 4'h0, 1, "R6");
    drive(1, 2'd0, 8'hC0, 32'h0000_6000, 4'b0001, 1, "R8"); // same-thread window kept
    drive(1, 2'd1, 8'h3C, 32'h0000_7000, 4'b1000, 0, "R8");
    for (int t = 0; t < 8; t++)
      drive(1, 2'(t), 8'(8'h81 >> (t % 3)), 32'h0001_0000 + 32'(t * 32), 4'h0, t[0], "R11");

    for (int c = 0; c < 600; c++) begin
      logic [7:0] m;
      logic [3:0] f;
      m = ($urandom % 4 == 0) ? 8'($urandom) : (8'hFF << ($urandom % 4));
      f = ($urandom % 12 == 0) ? (4'b1 << ($urandom % 4)) : 4'h0;
      drive($urandom % 3 != 0, 2'($urandom), m, $urandom, f, $urandom % 2 == 0, "R7");
    end

    for (int c = 0; c < 8; c++) drive(0, 2'd0, 8'h00, 32'h0, 4'h0, 1, "R5");
    @(negedge clk);
    #1;
    chk(lane_valid_o == 4'b0, "R5", "drained lanes", 64'(lane_valid_o), 64'h0);
    chk(sb.size() == 0, "R7", "scoreboard empty", 64'(sb.size()), 64'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule